// File: doc/BRIEF.md
# UART Receive Queue with Fill-Threshold Events

This block buffers received characters for a UART-style peripheral until the processor collects them. A character enters either from the serial receiver or, when the loopback control is set, from the transmit-data write path. The processor removes the oldest character by issuing a read strobe. The character appears on the read-data output one clock later.

The queue works in one of two modes, held in a two-state machine. In `MODE_HOLD` it keeps a single character, like a holding register. In `MODE_QUEUE` it keeps up to `DEPTH` (default 16) characters. The `enable` transition (MODE_HOLD to MODE_QUEUE) is taken when `fifo_en` is 1. The `disable` transition (MODE_QUEUE to MODE_HOLD) is taken when `fifo_en` is 0. In every other case the machine stays where it is. Both transitions flush the queue. The block compares its fill count against a trigger level chosen by a fractional-fill code. It raises a level event when the count climbs through that level, and a pending event while characters wait. It also reports full and empty flags, and a sticky overrun flag when characters are lost.

Top module: `uart_rx_queue`

## Requirements
- R1: Capacity is 16 in MODE_QUEUE and 1 in MODE_HOLD. `full` is 1 exactly when the count equals the capacity, and `empty` is 1 exactly when the count is 0. After reset the block is in MODE_HOLD with count 0 and all events and flags clear.
- R2: When `fifo_en` differs from the current mode, the mode changes at the next edge. At that same edge the count drops to 0, the level and pending events clear, and any push or read in that cycle is discarded. `overrun` keeps its value.
- R3: In MODE_QUEUE the trigger level depends on `trig_sel`: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 12, 4 gives 14, and 5 to 7 give 16. In MODE_HOLD the trigger level is 1.
- R4: `level_evt` becomes 1 after an accepted push that is not paired with a read, when that push moves the count from below the trigger level to at or above it.
- R5: `level_evt` is never set by a count that was already at or above the trigger level. For example, lowering the trigger level or pushing further characters does not set it. After a read, it is cleared if the remaining count is below the trigger level.
- R6: `pend_evt` becomes 1 after any accepted push. It is cleared after a read that leaves the queue empty.
- R7: A push into a full queue, with no read in the same cycle, is dropped and sets `overrun`. `overrun` stays at 1 until `ovr_clr` is pulsed, and a drop in the same cycle as `ovr_clr` wins.
- R8: Characters are read in arrival order. `rd_data` is updated at the edge that ends the cycle in which `rd_req` is high. A read of an empty queue returns 0 and leaves the count unchanged.
- R9: A push and a read in the same cycle leave the count unchanged. When the queue is full, such a push is accepted and `overrun` is not set.
- R10: With `loopback` set, characters are taken only from `tx_wr_valid`/`tx_wr_data` and `ser_valid` is ignored. With it clear, characters are taken only from `ser_valid`/`ser_data` and `tx_wr_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 selects MODE_QUEUE, 0 selects MODE_HOLD |
| trig_sel | input | 3 | Fractional-fill trigger code |
| loopback | input | 1 | Selects the transmit write path as the character source |
| ser_valid | input | 1 | Serial receiver delivers a character |
| ser_data | input | 8 | Serial character |
| tx_wr_valid | input | 1 | Transmit-data write strobe |
| tx_wr_data | input | 8 | Transmit-data write value |
| rd_req | input | 1 | Read strobe for the oldest character |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Character returned by the last read |
| count | output | 5 | Current fill count |
| full | output | 1 | Count equals capacity |
| empty | output | 1 | Count is zero |
| level_evt | output | 1 | Trigger level was crossed upward |
| pend_evt | output | 1 | Characters are waiting |
| overrun | output | 1 | Sticky lost-character flag |

## Verification
A push and a read can land on the same edge, and a mode change can land on the same edge as a push. The bench creates the first case by raising `ser_valid` and `rd_req` together on a partly filled queue and again on a full one. It expects the count and `overrun` to stay unchanged while `rd_data` returns the oldest character. It creates the second case by raising `fifo_en` and `ser_valid` in the same cycle, and expects an empty queue afterwards.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [0:0] {
        MODE_HOLD  = 1'b0,
        MODE_QUEUE = 1'b1
    } rxq_mode_e;

    // Trigger level in characters for a given mode and fill code.
    function automatic int rxq_trig_level(input logic q_on, input logic [2:0] sel, input int depth);
        int lvl;
        if (!q_on) begin
            lvl = 1;
        end else begin
            case (sel)
                3'd0:    lvl = depth / 8;
                3'd1:    lvl = depth / 4;
                3'd2:    lvl = depth / 2;
                3'd3:    lvl = (depth * 3) / 4;
                3'd4:    lvl = (depth * 7) / 8;
                default: lvl = depth;
            endcase
        end
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_mode_fsm.sv
module rxq_mode_fsm
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fifo_en,
    output rxq_mode_e       mode,
    output logic [CW-1:0]   cap,
    output logic            flush
);

    rxq_mode_e st, st_nxt;

    // next-state logic: enable / disable transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            MODE_HOLD:  if (fifo_en)  st_nxt = MODE_QUEUE;
            MODE_QUEUE: if (!fifo_en) st_nxt = MODE_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= MODE_HOLD;
        else        st <= st_nxt;
    end

    // outputs
    always_comb begin
        mode  = st;
        flush = (st_nxt != st);
        unique case (st)
            MODE_HOLD:  cap = CW'(1);
            MODE_QUEUE: cap = CW'(DEPTH);
        endcase
    end

    // R2: a flush lands the machine in the mode requested by fifo_en
    a_r2_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st == ($past(fifo_en) ? MODE_QUEUE : MODE_HOLD)));

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CW    = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [CW-1:0]   cap,
    input  logic            push,
    input  logic [DW-1:0]   push_data,
    input  logic            pop_req,
    output logic [CW-1:0]   count,
    output logic [CW-1:0]   cnt_nxt,
    output logic            push_ok,
    output logic            drop,
    output logic [DW-1:0]   rd_data
);

    // DEPTH is expected to be a power of two so the pointers wrap naturally.
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          pop_ok;

    always_comb begin
        pop_ok  = pop_req && (count != '0) && !flush;
        push_ok = push && !flush && ((count < cap) || pop_ok);
        drop    = push && !flush && !push_ok;
        if (flush)
            cnt_nxt = '0;
        else
            cnt_nxt = count + {{(CW-1){1'b0}}, push_ok} - {{(CW-1){1'b0}}, pop_ok};
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp      <= '0;
            rp      <= '0;
            count   <= '0;
            rd_data <= '0;
        end else begin
            if (pop_req) rd_data <= pop_ok ? mem[rp] : '0;
            if (flush) begin
                wp    <= '0;
                rp    <= '0;
                count <= '0;
            end else begin
                if (push_ok) wp <= wp + AW'(1);
                if (pop_ok)  rp <= rp + AW'(1);
                count <= cnt_nxt;
            end
        end
    end

    // R1: the count never exceeds the capacity of the current mode
    a_r1_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
        count <= cap);

    // R9: simultaneous accepted push and read keep the count
    a_r9_pushpop_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_req && count != '0) |=> (count == $past(count)));

    // R8: reading an empty queue returns zero
    a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && count == '0) |=> (rd_data == '0));

    // R2: a flush leaves the queue empty
    a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

endmodule

// File: rtl/rxq_events.sv
module rxq_events #(
    parameter int CW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            push_ok,
    input  logic            pop_req,
    input  logic            drop,
    input  logic            ovr_clr,
    input  logic [CW-1:0]   count,
    input  logic [CW-1:0]   cnt_nxt,
    input  logic [CW-1:0]   trig,
    output logic            level_evt,
    output logic            pend_evt,
    output logic            overrun
);

    logic lvl_n, pend_n;

    always_comb begin
        lvl_n  = level_evt;
        pend_n = pend_evt;
        if (push_ok && (count < trig) && (cnt_nxt >= trig)) lvl_n = 1'b1;
        if (pop_req && (cnt_nxt < trig))                    lvl_n = 1'b0;
        if (push_ok)                                        pend_n = 1'b1;
        if (pop_req && (cnt_nxt == '0))                     pend_n = 1'b0;
        if (flush) begin
            lvl_n  = 1'b0;
            pend_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_evt <= 1'b0;
            pend_evt  <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            level_evt <= lvl_n;
            pend_evt  <= pend_n;
            if (drop)         overrun <= 1'b1;
            else if (ovr_clr) overrun <= 1'b0;
        end
    end

    // R7: a dropped character leaves overrun set
    a_r7_drop_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> overrun);

    // R6: an accepted push leaves data pending
    a_r6_pend_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> pend_evt);

    // R4: the level event only rises as a result of a push
    a_r4_rise_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_evt) |-> $past(push_ok));

    // R5: a lone read from at or below the level leaves the event low
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_ok && count <= trig) |=> !level_evt);

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fifo_en,
    input  logic [2:0]      trig_sel,
    input  logic            loopback,
    input  logic            ser_valid,
    input  logic [DW-1:0]   ser_data,
    input  logic            tx_wr_valid,
    input  logic [DW-1:0]   tx_wr_data,
    input  logic            rd_req,
    input  logic            ovr_clr,
    output logic [DW-1:0]   rd_data,
    output logic [CW-1:0]   count,
    output logic            full,
    output logic            empty,
    output logic            level_evt,
    output logic            pend_evt,
    output logic            overrun
);

    rxq_mode_e       mode;
    logic [CW-1:0]   cap, cnt_nxt, trig;
    logic            flush, push, push_ok, drop;
    logic [DW-1:0]   push_data;

    // character source: loopback path or serial receiver
    always_comb begin
        push      = loopback ? tx_wr_valid : ser_valid;
        push_data = loopback ? tx_wr_data  : ser_data;
        trig      = CW'(rxq_trig_level(mode == MODE_QUEUE, trig_sel, DEPTH));
        full      = (count == cap);
        empty     = (count == '0);
    end

    rxq_mode_fsm #(.DEPTH(DEPTH), .CW(CW)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .mode    (mode),
        .cap     (cap),
        .flush   (flush)
    );

    rxq_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .cap       (cap),
        .push      (push),
        .push_data (push_data),
        .pop_req   (rd_req),
        .count     (count),
        .cnt_nxt   (cnt_nxt),
        .push_ok   (push_ok),
        .drop      (drop),
        .rd_data   (rd_data)
    );

    rxq_events #(.CW(CW)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_ok   (push_ok),
        .pop_req   (rd_req),
        .drop      (drop),
        .ovr_clr   (ovr_clr),
        .count     (count),
        .cnt_nxt   (cnt_nxt),
        .trig      (trig),
        .level_evt (level_evt),
        .pend_evt  (pend_evt),
        .overrun   (overrun)
    );

    // R10: with loopback set the serial input alone never grows the queue
    a_r10_serial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback && !tx_wr_valid && !rd_req && !flush) |=> (count == $past(count)));

endmodule

// File: tb/sim_uart_rx_queue.sv
module sim_uart_rx_queue;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [2:0] trig_sel = 3'd0;
    logic       loopback = 1'b0;
    logic       ser_valid = 1'b0;
    logic [7:0] ser_data = 8'h00;
    logic       tx_wr_valid = 1'b0;
    logic [7:0] tx_wr_data = 8'h00;
    logic       rd_req = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] count;
    logic       full, empty, level_evt, pend_evt, overrun;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    uart_rx_queue u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .loopback(loopback), .ser_valid(ser_valid), .ser_data(ser_data),
        .tx_wr_valid(tx_wr_valid), .tx_wr_data(tx_wr_data), .rd_req(rd_req),
        .ovr_clr(ovr_clr), .rd_data(rd_data), .count(count), .full(full),
        .empty(empty), .level_evt(level_evt), .pend_evt(pend_evt), .overrun(overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, release 1 ns after the edge
    task automatic step(input bit sv, input logic [7:0] sd, input bit tv,
                        input logic [7:0] td, input bit rd, input bit oc);
        @(negedge clk);
        ser_valid = sv; ser_data = sd; tx_wr_valid = tv; tx_wr_data = td;
        rd_req = rd; ovr_clr = oc;
        @(posedge clk);
        #1;
        ser_valid = 1'b0; tx_wr_valid = 1'b0; rd_req = 1'b0; ovr_clr = 1'b0;
    endtask

    task automatic push(input logic [7:0] d); step(1'b1, d, 1'b0, 8'h00, 1'b0, 1'b0); endtask
    task automatic pop();                     step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0); endtask

    task automatic set_mode(input bit en);
        @(negedge clk);
        fifo_en = en;
        @(posedge clk);
        #1;
    endtask

    task automatic requeue(input logic [2:0] code);
        set_mode(1'b0);
        @(negedge clk);
        trig_sel = code;
        set_mode(1'b1);
    endtask

    task automatic t_reset();
        chk("R1 reset count", count, 0);
        chk("R1 reset empty", empty, 1);
        chk("R1 reset full", full, 0);
        chk("R6 reset pend", pend_evt, 0);
        chk("R4 reset level", level_evt, 0);
        chk("R7 reset overrun", overrun, 0);
        chk("R8 reset rd_data", rd_data, 0);
    endtask

    task automatic t_hold_mode();
        push(8'hA5);
        chk("R1 hold full", full, 1);
        chk("R3 hold trig level 1", level_evt, 1);
        chk("R6 hold pend", pend_evt, 1);
        push(8'h3C);
        chk("R7 hold drop count", count, 1);
        chk("R7 hold overrun", overrun, 1);
        pop();
        chk("R8 hold read", rd_data, 8'hA5);
        chk("R1 hold empty", empty, 1);
        chk("R5 hold level cleared", level_evt, 0);
        chk("R6 hold pend cleared", pend_evt, 0);
        chk("R7 overrun sticky", overrun, 1);
        step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R7 overrun cleared", overrun, 0);
    endtask

    task automatic t_fill_queue();
        requeue(3'd2);
        for (int i = 0; i < 16; i++) begin
            push(8'(8'h10 + i));
            chk("R4 level during fill", level_evt, (i + 1 >= 8) ? 1 : 0);
        end
        chk("R1 queue count 16", count, 16);
        chk("R1 queue full", full, 1);
        push(8'hEE);
        chk("R7 queue drop", count, 16);
        chk("R7 queue overrun", overrun, 1);
        for (int i = 0; i < 16; i++) begin
            pop();
            chk("R8 order", rd_data, 8'h10 + i);
            chk("R5 level after read", level_evt, (15 - i >= 8) ? 1 : 0);
            chk("R6 pend after read", pend_evt, (15 - i > 0) ? 1 : 0);
        end
        pop();
        chk("R8 empty read data", rd_data, 0);
        chk("R8 empty read count", count, 0);
        step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_trig_codes();
        for (int c = 0; c < 8; c++) begin
            int first = 0;
            int exp;
            exp = (c == 0) ? 2 : (c == 1) ? 4 : (c == 2) ? 8 :
                  (c == 3) ? 12 : (c == 4) ? 14 : 16;
            requeue(3'(c));
            for (int k = 1; k <= 16; k++) begin
                push(8'(k));
                if (level_evt && first == 0) first = k;
            end
            chk("R3 trigger level for code", first, exp);
        end
    endtask

    task automatic t_no_recross();
        requeue(3'd4);
        for (int k = 0; k < 10; k++) push(8'(k));
        chk("R5 below level", level_evt, 0);
        @(negedge clk);
        trig_sel = 3'd0;
        push(8'h55);
        chk("R5 no set when already above", level_evt, 0);
        chk("R5 count 11", count, 11);
    endtask

    task automatic t_same_cycle();
        requeue(3'd0);
        push(8'h11); push(8'h22); push(8'h33);
        step(1'b1, 8'h44, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R9 count unchanged", count, 3);
        chk("R9 read oldest", rd_data, 8'h11);
        for (int k = 0; k < 13; k++) push(8'(8'h60 + k));
        chk("R1 full before pair", full, 1);
        step(1'b1, 8'h99, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R9 full pair count", count, 16);
        chk("R9 full pair no overrun", overrun, 0);
        chk("R9 full pair data", rd_data, 8'h22);
        pop();
        chk("R8 order after pair", rd_data, 8'h33);
    endtask

    task automatic t_loopback();
        requeue(3'd0);
        loopback = 1'b1;
        step(1'b1, 8'h77, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R10 serial ignored in loopback", count, 0);
        step(1'b0, 8'h00, 1'b1, 8'h88, 1'b0, 1'b0);
        chk("R10 tx accepted in loopback", count, 1);
        @(negedge clk);
        loopback = 1'b0;
        step(1'b0, 8'h00, 1'b1, 8'h99, 1'b0, 1'b0);
        chk("R10 tx ignored without loopback", count, 1);
        pop();
        chk("R10 looped character", rd_data, 8'h88);
    endtask

    task automatic t_mode_switch();
        requeue(3'd0);
        for (int k = 0; k < 17; k++) push(8'(k));
        chk("R2 pre overrun", overrun, 1);
        chk("R2 pre level", level_evt, 1);
        set_mode(1'b0);
        chk("R2 switch count", count, 0);
        chk("R2 switch empty", empty, 1);
        chk("R2 switch level", level_evt, 0);
        chk("R2 switch pend", pend_evt, 0);
        chk("R2 switch keeps overrun", overrun, 1);
        @(negedge clk);
        fifo_en = 1'b1; ser_valid = 1'b1; ser_data = 8'hCC;
        @(posedge clk);
        #1;
        ser_valid = 1'b0;
        chk("R2 push during switch dropped", count, 0);
        push(8'hDD);
        chk("R1 queue capacity after enable", full, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_hold_mode();
        t_fill_queue();
        t_trig_codes();
        t_no_recross();
        t_same_cycle();
        t_loopback();
        t_mode_switch();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule